// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block serialises characters taken from an external queue into asynchronous line frames. Each frame is a low start bit, then six, seven or eight data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. A mode word selects the character length, the parity kind and the stop-bit count. The block samples the mode word when it takes a character, so each frame keeps the settings it started with. An external baud generator supplies `bit_tick`, a one-cycle pulse per bit period. Every line bit starts on a tick and lasts until the next tick.

A control strobe carries five command bits. They enable or disable the transmitter, reset its frame state, and start or end a line break. A break that is requested while a frame is in progress waits for that frame to finish. It then holds the line low until it is released, and no characters are taken from the queue during that time.

The framer has six states:
- `ST_IDLE`: the line is high.
- `ST_START`: the start bit is on the line.
- `ST_DATA`: the data bits are on the line.
- `ST_PARITY`: the parity bit is on the line.
- `ST_STOP`: the stop bits are on the line.
- `ST_BREAK`: the line is held low.

The transitions are:
- IDLE to BREAK when a break is pending.
- IDLE to START when a character is taken.
- START to DATA on a tick.
- DATA to PARITY or to STOP on the tick that ends the last data bit.
- PARITY to STOP on a tick.
- STOP stays in STOP on the first tick of a two-stop frame.
- STOP to IDLE on the tick that ends the last stop bit.
- BREAK to IDLE when the break is released.
- Any state to IDLE on a transmitter reset.

Top module: `uart_frame_tx`

## Requirements
- R1: When the block is idle, enabled and not in break, it takes a character on a cycle where `q_valid` and `bit_tick` are both high, with `q_ready` high for that one cycle. From the next cycle `txd` carries a low start bit, the data bits LSB first, the parity bit if any, and the stop bits, high. Each bit changes only on a `bit_tick` cycle. An idle line is high.
- R2: `mode_word[1:0]` selects the character length: 11 gives 6 data bits, 10 gives 7 data bits, and 00 or 01 gives 8 data bits. The mode word is sampled when the character is taken.
- R3: `mode_word[4:2]` selects the parity bit: 000 even (the parity bit makes the count of ones among the sent data bits and the parity bit even), 001 odd, 010 always 0, 011 always 1. Any value with bit 4 set sends no parity bit.
- R4: `mode_word[6:5]` equal to 10 sends two stop bits. Any other value sends one stop bit.
- R5: Only `q_data[7:0]` forms the character. Higher bits of the queue word have no effect on the line.
- R6: `ctrl_word` bit 1 enables the transmitter and bit 2 disables it. If both are set, disable wins. The transmitter is disabled after reset. When disabled, the block takes no characters, and a frame in progress still completes.
- R7: `ctrl_word` bit 0 abandons any frame or break at once and returns the line to idle high. The same write also clears the break request and ignores a break start. Enable and disable bits in that write still apply.
- R8: `ctrl_word` bit 3 requests a break and bit 4 releases it; if both are set, release wins. A requested break drives `txd` low from the cycle after the framer is idle. A frame in progress completes first. No characters are taken while a break is requested or in progress.
- R9: `tx_active` is high exactly while a frame is on the line, from the first cycle of the start bit through the last cycle of the final stop bit.
- R10: `tx_done` is a one-cycle pulse. It is high in the cycle after a frame's last stop bit ends, but only if `q_valid` was low when that bit ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit period from the baud generator |
| mode_word | input | 7 | Length [1:0], parity [4:2], stop count [6:5] |
| ctrl_wr | input | 1 | Strobe that applies `ctrl_word` for one cycle |
| ctrl_word | input | 5 | Reset [0], enable [1], disable [2], break start [3], break stop [4] |
| q_valid | input | 1 | Queue holds a character |
| q_data | input | WORD_W | Queue head word; the low 8 bits form the character |
| q_ready | output | 1 | Pop strobe to the queue |
| txd | output | 1 | Serial line output |
| tx_active | output | 1 | A frame is on the line |
| tx_done | output | 1 | Pulse when the last frame has finished and the queue is empty |

## Verification
The assertions check, on every cycle:
- that the line holds steady between ticks during a frame;
- that a start bit follows every pop;
- that a pending break keeps the line low once the framer is idle and blocks pops;
- that a write with both enable and disable leaves the transmitter disabled;
- that `tx_done` is a single-cycle pulse on an idle-high line.

The exact bit sequences need the bench's frame-building reference model, compared on every clock. These include parity polarity for each kind, the 6, 7 and 8 bit lengths, one or two stop bits, and truncation of wide queue words. The same holds for deferring a break behind an active frame, and for a reset that overrides a break start in the same write.

// File: rtl/uart_frame_tx_pkg.sv
package uart_frame_tx_pkg;
    localparam int MODE_W = 7;
    localparam int CTRL_W = 5;
    localparam int C_RST     = 0;
    localparam int C_EN      = 1;
    localparam int C_DIS     = 2;
    localparam int C_BRK_ON  = 3;
    localparam int C_BRK_OFF = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP, ST_BREAK
    } tx_state_e;

    typedef enum logic [1:0] {
        PB_EVEN, PB_ODD, PB_ZERO, PB_ONE
    } par_kind_e;

    typedef struct packed {
        logic [1:0] len_sel;
        logic       par_on;
        par_kind_e  par_kind;
        logic       two_stop;
    } frame_cfg_t;
endpackage

// File: rtl/uart_frame_tx_mode.sv
module uart_frame_tx_mode
    import uart_frame_tx_pkg::*;
(
    input  logic [MODE_W-1:0] mode_word,
    output frame_cfg_t        cfg
);
    always_comb begin
        cfg.len_sel  = mode_word[1:0];
        cfg.par_on   = ~mode_word[4];
        cfg.par_kind = par_kind_e'(mode_word[3:2]);
        cfg.two_stop = (mode_word[6:5] == 2'b10);
    end
endmodule

// File: rtl/uart_frame_tx_ctrl.sv
module uart_frame_tx_ctrl
    import uart_frame_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic              soft_rst,
    output logic              en_q,
    output logic              brk_q
);
    assign soft_rst = ctrl_wr & ctrl_word[C_RST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            brk_q <= 1'b0;
        end else if (ctrl_wr) begin
            if (ctrl_word[C_DIS])      en_q <= 1'b0;
            else if (ctrl_word[C_EN])  en_q <= 1'b1;
            if (ctrl_word[C_RST] || ctrl_word[C_BRK_OFF]) brk_q <= 1'b0;
            else if (ctrl_word[C_BRK_ON])                 brk_q <= 1'b1;
        end
    end

    assert_disable_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_word[C_DIS]) |=> !en_q)
        else $error("disable did not win");

    assert_reset_clears_break_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_word[C_RST]) |=> !brk_q)
        else $error("reset left break pending");
endmodule

// File: rtl/uart_frame_tx_fsm.sv
module uart_frame_tx_fsm
    import uart_frame_tx_pkg::*;
#(
    parameter int CHAR_W = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              soft_rst,
    input  logic              tx_en,
    input  logic              brk_hold,
    input  frame_cfg_t        cfg_in,
    input  logic              q_valid,
    input  logic [CHAR_W-1:0] q_char,
    output logic              q_ready,
    output logic              txd,
    output logic              tx_active,
    output logic              tx_done
);
    localparam int CNT_W = $clog2(CHAR_W);

    tx_state_e         state;
    logic [CHAR_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    frame_cfg_t        cfg_q;
    logic              par_bit;
    logic              done_q;
    logic              take;
    logic [CHAR_W-1:0] masked;
    logic              par_calc;
    logic [CNT_W-1:0]  load_last;
    logic [CNT_W-1:0]  run_last;

    function automatic logic [CNT_W-1:0] last_index(input logic [1:0] sel);
        unique case (sel)
            2'b11:   return CNT_W'(CHAR_W - 3);
            2'b10:   return CNT_W'(CHAR_W - 2);
            default: return CNT_W'(CHAR_W - 1);
        endcase
    endfunction

    assign load_last = last_index(cfg_in.len_sel);
    assign run_last  = last_index(cfg_q.len_sel);
    assign take = (state == ST_IDLE) && !brk_hold && tx_en && q_valid
                  && bit_tick && !soft_rst;

    always_comb begin
        for (int i = 0; i < CHAR_W; i++)
            masked[i] = q_char[i] & (i <= int'(load_last));
        unique case (cfg_in.par_kind)
            PB_EVEN: par_calc = ^masked;
            PB_ODD:  par_calc = ~^masked;
            PB_ZERO: par_calc = 1'b0;
            default: par_calc = 1'b1;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            cnt     <= '0;
            cfg_q   <= '0;
            par_bit <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (soft_rst) begin
                state <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        if (brk_hold) begin
                            state <= ST_BREAK;
                        end else if (take) begin
                            state   <= ST_START;
                            shreg   <= masked;
                            cfg_q   <= cfg_in;
                            par_bit <= par_calc;
                        end
                    end
                    ST_START: if (bit_tick) begin
                        state <= ST_DATA;
                        cnt   <= '0;
                    end
                    ST_DATA: if (bit_tick) begin
                        shreg <= shreg >> 1;
                        if (cnt == run_last) begin
                            state <= cfg_q.par_on ? ST_PARITY : ST_STOP;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_PARITY: if (bit_tick) begin
                        state <= ST_STOP;
                        cnt   <= '0;
                    end
                    ST_STOP: if (bit_tick) begin
                        if (cfg_q.two_stop && cnt == '0) begin
                            cnt <= CNT_W'(1);
                        end else begin
                            state  <= ST_IDLE;
                            done_q <= !q_valid;
                        end
                    end
                    ST_BREAK: if (!brk_hold) state <= ST_IDLE;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg[0];
            ST_PARITY: txd = par_bit;
            ST_BREAK:  txd = 1'b0;
            default:   txd = 1'b1;
        endcase
        tx_active = (state == ST_START) || (state == ST_DATA) ||
                    (state == ST_PARITY) || (state == ST_STOP);
        q_ready   = take;
        tx_done   = done_q;
    end

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done)
        else $error("done longer than one cycle");

    assert_done_idle_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (txd && !tx_active))
        else $error("done while line not idle");
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_frame_tx_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CHAR_W = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              q_valid,
    input  logic [WORD_W-1:0] q_data,
    output logic              q_ready,
    output logic              txd,
    output logic              tx_active,
    output logic              tx_done
);
    frame_cfg_t cfg;
    logic       soft_rst;
    logic       en_q;
    logic       brk_q;

    generate
        if (WORD_W > CHAR_W) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^q_data[WORD_W-1:CHAR_W];
        end
    endgenerate

    uart_frame_tx_mode u_mode (
        .mode_word (mode_word),
        .cfg       (cfg)
    );

    uart_frame_tx_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_word (ctrl_word),
        .soft_rst  (soft_rst),
        .en_q      (en_q),
        .brk_q     (brk_q)
    );

    uart_frame_tx_fsm #(.CHAR_W(CHAR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .soft_rst  (soft_rst),
        .tx_en     (en_q),
        .brk_hold  (brk_q),
        .cfg_in    (cfg),
        .q_valid   (q_valid),
        .q_char    (q_data[CHAR_W-1:0]),
        .q_ready   (q_ready),
        .txd       (txd),
        .tx_active (tx_active),
        .tx_done   (tx_done)
    );

    assert_start_after_pop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        q_ready |=> (!txd && tx_active))
        else $error("no start bit after pop");

    assert_line_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && !bit_tick && !soft_rst) |=> $stable(txd))
        else $error("line moved between ticks");

    assert_break_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_q && !tx_active && !soft_rst) |=> !txd)
        else $error("break not driving line low");

    assert_no_pop_in_break_R8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_q |-> !q_ready)
        else $error("pop during break");

    assert_no_pop_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !q_ready)
        else $error("pop while disabled");
endmodule

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;
    localparam int WORD_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bit_tick = 1'b0;
    logic [6:0]        mode_word = 7'h10;
    logic              ctrl_wr = 1'b0;
    logic [4:0]        ctrl_word = '0;
    logic              q_valid = 1'b0;
    logic [WORD_W-1:0] q_data = '0;
    logic              q_ready, txd, tx_active, tx_done;

    always #2 clk = ~clk;

    uart_frame_tx #(.WORD_W(WORD_W)) u_uart_frame_tx (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .mode_word(mode_word),
        .ctrl_wr(ctrl_wr), .ctrl_word(ctrl_word), .q_valid(q_valid),
        .q_data(q_data), .q_ready(q_ready), .txd(txd),
        .tx_active(tx_active), .tx_done(tx_done)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;
    string cur_req = "R1 reset";

    logic [WORD_W-1:0] txq[$];
    bit m_en, m_brk, m_busy, m_inbrk, m_done;
    int m_pos, m_len;
    logic [15:0] m_bits;

    task automatic chk(input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0b expected=%0b", cur_req, what, act, exp);
        end
    endtask

    function automatic bit exp_pop();
        return !m_busy && !m_inbrk && !m_brk && m_en && q_valid && bit_tick
               && !(ctrl_wr && ctrl_word[0]);
    endfunction

    task automatic build(input logic [7:0] ch, input logic [6:0] md);
        int n;
        int ones;
        n = (md[1:0] == 2'b11) ? 6 : (md[1:0] == 2'b10) ? 7 : 8;
        m_bits = '0;
        m_bits[0] = 1'b0;
        ones = 0;
        for (int i = 0; i < n; i++) begin
            m_bits[1+i] = ch[i];
            if (ch[i]) ones++;
        end
        m_len = 1 + n;
        if (!md[4]) begin
            case (md[3:2])
                2'b00: m_bits[m_len] = (ones % 2 == 1);
                2'b01: m_bits[m_len] = (ones % 2 == 0);
                2'b10: m_bits[m_len] = 1'b0;
                default: m_bits[m_len] = 1'b1;
            endcase
            m_len++;
        end
        m_bits[m_len] = 1'b1;
        m_len++;
        if (md[6:5] == 2'b10) begin
            m_bits[m_len] = 1'b1;
            m_len++;
        end
    endtask

    // reference model, advanced on each clock
    always @(posedge clk) begin
        bit pop_now;
        bit done_n;
        pop_now = exp_pop();
        done_n = 0;
        if (!rst_n) begin
            m_en = 0; m_brk = 0; m_busy = 0; m_inbrk = 0; m_done = 0;
            m_pos = 0; m_len = 0;
        end else begin
            if (ctrl_wr && ctrl_word[0]) begin
                m_busy = 0; m_inbrk = 0;
            end else if (m_busy) begin
                if (bit_tick) begin
                    if (m_pos == m_len - 1) begin
                        m_busy = 0;
                        done_n = !q_valid;
                    end else m_pos++;
                end
            end else if (m_inbrk) begin
                if (!m_brk) m_inbrk = 0;
            end else if (m_brk) begin
                m_inbrk = 1;
            end else if (pop_now) begin
                build(q_data[7:0], mode_word);
                m_busy = 1;
                m_pos = 0;
            end
            m_done = done_n;
            if (ctrl_wr) begin
                if (ctrl_word[0] || ctrl_word[4]) m_brk = 0;
                else if (ctrl_word[3]) m_brk = 1;
                if (ctrl_word[2]) m_en = 0;
                else if (ctrl_word[1]) m_en = 1;
            end
            if (pop_now) void'(txq.pop_front());
        end
        q_valid <= (txq.size() > 0);
        q_data  <= (txq.size() > 0) ? txq[0] : '0;
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R1 txd", txd, m_inbrk ? 1'b0 : (m_busy ? m_bits[m_pos] : 1'b1));
            chk("R9 tx_active", tx_active, m_busy);
            chk("R10 tx_done", tx_done, m_done);
            chk("R6 q_ready", q_ready, exp_pop());
        end
    end

    initial begin
        int tc;
        tc = 0;
        forever begin
            @(negedge clk); #1;
            tc++;
            bit_tick = (tc % 4 == 0);
        end
    end

    task automatic ctrl(input logic [4:0] w);
        @(negedge clk); #1;
        ctrl_wr = 1'b1; ctrl_word = w;
        @(negedge clk); #1;
        ctrl_wr = 1'b0; ctrl_word = '0;
    endtask

    task automatic drain();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (txq.size() == 0 && !m_busy && !q_valid) break;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic send(input string tag, input logic [6:0] md, input logic [WORD_W-1:0] w);
        cur_req = tag;
        @(negedge clk); #1;
        mode_word = md;
        txq.push_back(w);
        drain();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R1 reset txd", txd, 1'b1);
        chk("R9 reset active", tx_active, 1'b0);
        chk("R10 reset done", tx_done, 1'b0);
        chk("R6 reset q_ready", q_ready, 1'b0);
        #1 rst_n = 1'b1;
        cur_req = "R6 disabled after reset";
        txq.push_back(32'h5A);
        repeat (40) @(negedge clk);
        n_checks++;
        if (txq.size() != 1) begin
            n_fail++;
            $display("FAIL R6 reset-disabled: actual=%0d expected=1", txq.size());
        end
        cur_req = "R1 8N1";
        ctrl(5'b00010);
        drain();
        send("R1 8N1 A5", 7'h10, 32'hA5);
        send("R5 wide word", 7'h10, 32'h1234_56C3);
        send("R2 six bits", 7'h13, 32'hFF);
        send("R2 seven bits", 7'h12, 32'hFF);
        send("R2 eight bits 01", 7'h11, 32'h81);
        send("R3 even", 7'h00, 32'h37);
        send("R3 odd", 7'h04, 32'h37);
        send("R3 space", 7'h08, 32'hFF);
        send("R3 mark", 7'h0C, 32'h00);
        send("R3 odd seven", 7'h06, 32'hC1);
        send("R4 two stops", 7'h50, 32'h3C);
        send("R4 value 11 one stop", 7'h70, 32'h3C);

        cur_req = "R10 back-to-back";
        @(negedge clk); #1;
        mode_word = 7'h44;
        txq.push_back(32'h11); txq.push_back(32'h22); txq.push_back(32'h33);
        drain();

        cur_req = "R6 enable and disable together";
        ctrl(5'b00110);
        txq.push_back(32'h99);
        repeat (60) @(negedge clk);
        n_checks++;
        if (txq.size() != 1) begin
            n_fail++;
            $display("FAIL R6 disable-wins: actual=%0d expected=1", txq.size());
        end
        ctrl(5'b00010);
        drain();

        cur_req = "R8 break deferred";
        @(negedge clk); #1;
        mode_word = 7'h10;
        txq.push_back(32'hC3);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (m_busy) break;
        end
        ctrl(5'b01000);
        txq.push_back(32'h81);
        repeat (150) @(negedge clk);
        n_checks++;
        if (txq.size() != 1 || txd !== 1'b0) begin
            n_fail++;
            $display("FAIL R8 break-hold: actual=%0d/%0b expected=1/0", txq.size(), txd);
        end
        cur_req = "R8 release wins";
        ctrl(5'b11000);
        drain();

        cur_req = "R7 reset mid-frame";
        @(negedge clk); #1;
        txq.push_back(32'h55);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (m_busy && m_pos == 3) break;
        end
        ctrl(5'b01001);
        repeat (30) @(negedge clk);
        n_checks++;
        if (txd !== 1'b1 || tx_active !== 1'b0) begin
            n_fail++;
            $display("FAIL R7 abandon: actual=%0b%0b expected=10", txd, tx_active);
        end
        send("R7 after reset still enabled", 7'h10, 32'h0F);
        summary();
    end
endmodule